// File: doc/BRIEF.md
# Paravirtual Queue Device Register Block

This block is the register front end of a legacy paravirtual I/O function with a single queue. It decodes a 256-byte, byte-addressed register window. A host driver uses that window to read the device's feature word, program the page frame number of the queue, select a queue, ring the queue doorbell, walk the device through its status handshake and acknowledge interrupts. The window also gives byte-granular read access to a block of device-specific configuration bytes. The configuration bytes come in on a port from the device model.

Accesses are single-cycle. A register is selected by its exact byte offset and by an access width equal to the register's own width. Read data is combinational and valid in the cycle of the request. Side effects take hold at the clock edge that ends the access: storing a value, clearing the interrupt status, or raising a pulse. The completion logic reports finished work on `irq_post`, which latches an interrupt status bit and holds the interrupt line high until the driver reads the status byte. The doorbell appears as a one-cycle pulse that carries the queue number written. Writing zero to the status byte resets the block and pulses `soft_reset`, so that the queue-walking logic can clear its own indices.

Top module: `pvio_regs`

## Requirements
- R1: After reset, queue_pfn, queue_sel and dev_status are 0, irq is low, and notify_valid and soft_reset are low.
- R2: A word read (size 2) at offset 0x00 returns 1. A word write at offset 0x04 changes no output and no readable register.
- R3: A word write at offset 0x08 stores the 32-bit page frame number, which queue_pfn shows. A word read at 0x08 returns that value when queue_sel is 0 and returns 0 when it is not.
- R4: A halfword read (size 1) at offset 0x0C returns the queue size 32. The value never changes.
- R5: A halfword write at offset 0x0E stores the queue select value, which queue_sel shows. A halfword read at 0x0E returns it.
- R6: A halfword write at offset 0x10 raises notify_valid for exactly the next cycle, with notify_queue equal to wdata[15:0].
- R7: A byte write (size 0) at offset 0x12 with a nonzero value stores it in dev_status (bit 0 acknowledge, bit 1 driver, bit 2 driver ready, bit 7 failed). A byte read at 0x12 returns it.
- R8: A byte write of 0 at offset 0x12 clears queue_sel, dev_status, queue_pfn and the interrupt status at the next edge, and raises soft_reset for exactly one cycle.
- R9: irq_post high at an edge sets bit 0 of the interrupt status, and irq is high from that edge on.
- R10: A byte read at offset 0x13 returns the interrupt status in that cycle and clears it at the edge, and irq is low afterwards.
- R11: When irq_post coincides with an interrupt status read or a zero status write, the post wins: bit 0 stays set and irq stays high.
- R12: Reads of any size 0 to 2 at offsets 0x14 to 0x93 return configuration bytes, little-endian, lane k taking byte (addr - 0x14 + k). Bytes at index CFG_LEN or above read as 0. Writes to the window change nothing.
- R13: An access at an unmapped offset, or with a size other than the register's width (including size 3), reads 0 and has no side effect. A write of that kind is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset in the register window |
| bus_rd | input | 1 | Read request this cycle |
| bus_wr | input | 1 | Write request this cycle |
| bus_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, combinational, zero-extended |
| irq_post | input | 1 | Completion logic requests an interrupt |
| cfg_bytes | input | 8*CFG_LEN | Device configuration bytes, byte i at bits 8i+7:8i |
| queue_pfn | output | 32 | Stored queue page frame number |
| queue_sel | output | 16 | Stored queue select |
| dev_status | output | 8 | Stored device status byte |
| notify_valid | output | 1 | One-cycle doorbell pulse |
| notify_queue | output | 16 | Queue number of the doorbell |
| soft_reset | output | 1 | One-cycle pulse after a zero status write |
| irq | output | 1 | Level interrupt line |

## Verification
The assertions assume that the bus never requests a read and a write in the same cycle, and they check that rule as an input condition. They also assume that bus inputs are steady around the clock edge. The stimulus drives exactly one of read, write or idle per cycle and changes inputs only on the falling edge. The random phase sends every size code, including the reserved one, to mapped, unmapped and window offsets, with zero status writes and interrupt posts mixed in. This covers collisions between posts and clears.

// File: rtl/pvio_pkg.sv
package pvio_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    localparam logic [7:0] OFF_FEATURE = 8'h00;
    localparam logic [7:0] OFF_PFN     = 8'h08;
    localparam logic [7:0] OFF_QSIZE   = 8'h0C;
    localparam logic [7:0] OFF_QSEL    = 8'h0E;
    localparam logic [7:0] OFF_NOTIFY  = 8'h10;
    localparam logic [7:0] OFF_STATUS  = 8'h12;
    localparam logic [7:0] OFF_ISR     = 8'h13;
    localparam logic [7:0] OFF_CFG_LO  = 8'h14;
    localparam logic [7:0] OFF_CFG_HI  = 8'h93;

    localparam logic [31:0] FEATURE_WORD = 32'd1;
    localparam logic [15:0] QUEUE_DEPTH  = 16'd32;
    localparam int          LANES        = 4;

    typedef struct packed {
        logic feat_rd;
        logic pfn_rd;
        logic pfn_wr;
        logic qsize_rd;
        logic sel_rd;
        logic sel_wr;
        logic notify_wr;
        logic stat_rd;
        logic stat_wr;
        logic isr_rd;
        logic cfg_rd;
    } reg_hit_t;

    function automatic int lane_count(acc_size_e sz);
        case (sz)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            SZ_WORD: return 4;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/pvio_decode.sv
module pvio_decode
    import pvio_pkg::*;
(
    input  logic [7:0] bus_addr,
    input  acc_size_e  bus_size,
    input  logic       bus_rd,
    input  logic       bus_wr,
    output reg_hit_t   hit
);
    function automatic logic at(logic [7:0] a, logic [7:0] off, acc_size_e s, acc_size_e w);
        return (a == off) && (s == w);
    endfunction

    logic in_window;
    assign in_window = (bus_addr >= OFF_CFG_LO) && (bus_addr <= OFF_CFG_HI) && (bus_size != SZ_RSVD);

    always_comb begin
        hit           = '0;
        hit.feat_rd   = bus_rd && at(bus_addr, OFF_FEATURE, bus_size, SZ_WORD);
        hit.pfn_rd    = bus_rd && at(bus_addr, OFF_PFN,     bus_size, SZ_WORD);
        hit.pfn_wr    = bus_wr && at(bus_addr, OFF_PFN,     bus_size, SZ_WORD);
        hit.qsize_rd  = bus_rd && at(bus_addr, OFF_QSIZE,   bus_size, SZ_HALF);
        hit.sel_rd    = bus_rd && at(bus_addr, OFF_QSEL,    bus_size, SZ_HALF);
        hit.sel_wr    = bus_wr && at(bus_addr, OFF_QSEL,    bus_size, SZ_HALF);
        hit.notify_wr = bus_wr && at(bus_addr, OFF_NOTIFY,  bus_size, SZ_HALF);
        hit.stat_rd   = bus_rd && at(bus_addr, OFF_STATUS,  bus_size, SZ_BYTE);
        hit.stat_wr   = bus_wr && at(bus_addr, OFF_STATUS,  bus_size, SZ_BYTE);
        hit.isr_rd    = bus_rd && at(bus_addr, OFF_ISR,     bus_size, SZ_BYTE);
        hit.cfg_rd    = bus_rd && in_window;
    end
endmodule

// File: rtl/pvio_cfg_window.sv
module pvio_cfg_window
    import pvio_pkg::*;
#(
    parameter int CFG_LEN = 8
) (
    input  logic [7:0]           win_addr,
    input  acc_size_e            win_size,
    input  logic [CFG_LEN*8-1:0] cfg_bytes,
    output logic [31:0]          win_data
);
    localparam int IDX_W = 9;

    logic [IDX_W-1:0] base;
    assign base = {1'b0, win_addr - OFF_CFG_LO};

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [IDX_W-1:0] idx;
        logic             live;
        int               safe_idx;
        assign idx      = base + IDX_W'(k);
        assign live     = (k < lane_count(win_size)) && (int'(idx) < CFG_LEN);
        assign safe_idx = live ? int'(idx) : 0;
        assign win_data[k*8 +: 8] = live ? cfg_bytes[safe_idx*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/pvio_isr.sv
module pvio_isr (
    input  logic       clk,
    input  logic       rst,
    input  logic       post,
    input  logic       clear,
    output logic [7:0] isr_value,
    output logic       irq
);
    logic [7:0] isr_q;

    always_ff @(posedge clk) begin
        if (rst) isr_q <= 8'h00;
        else     isr_q <= (clear ? 8'h00 : isr_q) | {7'b0, post};
    end

    assign isr_value = isr_q;
    assign irq       = |isr_q;

    assert_post_raises_R9: assert property (@(posedge clk) disable iff (rst)
        post |=> irq);
    assert_rise_has_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(post));
    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (rst)
        (clear && !post) |=> !irq);
    assert_post_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (clear && post) |=> isr_value == 8'h01);
endmodule

// File: rtl/pvio_regs.sv
module pvio_regs
    import pvio_pkg::*;
#(
    parameter int CFG_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [1:0]           bus_size,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 irq_post,
    input  logic [CFG_LEN*8-1:0] cfg_bytes,
    output logic [31:0]          queue_pfn,
    output logic [15:0]          queue_sel,
    output logic [7:0]           dev_status,
    output logic                 notify_valid,
    output logic [15:0]          notify_queue,
    output logic                 soft_reset,
    output logic                 irq
);
    acc_size_e  size_e;
    reg_hit_t   hit;
    logic [31:0] cfg_rdata;
    logic [7:0]  isr_value;
    logic        zero_status_wr;

    assign size_e = acc_size_e'(bus_size);

    pvio_decode u_dec (
        .bus_addr (bus_addr),
        .bus_size (size_e),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .hit      (hit)
    );

    pvio_cfg_window #(.CFG_LEN(CFG_LEN)) u_cfg (
        .win_addr  (bus_addr),
        .win_size  (size_e),
        .cfg_bytes (cfg_bytes),
        .win_data  (cfg_rdata)
    );

    assign zero_status_wr = hit.stat_wr && (bus_wdata[7:0] == 8'h00);

    pvio_isr u_isr (
        .clk       (clk),
        .rst       (rst),
        .post      (irq_post),
        .clear     (hit.isr_rd || zero_status_wr),
        .isr_value (isr_value),
        .irq       (irq)
    );

    logic [31:0] pfn_q;
    logic [15:0] sel_q;
    logic [7:0]  status_q;

    always_ff @(posedge clk) begin
        if (rst || zero_status_wr) begin
            pfn_q    <= '0;
            sel_q    <= '0;
            status_q <= '0;
        end else begin
            if (hit.pfn_wr)  pfn_q    <= bus_wdata;
            if (hit.sel_wr)  sel_q    <= bus_wdata[15:0];
            if (hit.stat_wr) status_q <= bus_wdata[7:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            notify_valid <= 1'b0;
            notify_queue <= '0;
            soft_reset   <= 1'b0;
        end else begin
            notify_valid <= hit.notify_wr;
            if (hit.notify_wr) notify_queue <= bus_wdata[15:0];
            soft_reset   <= zero_status_wr;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit.feat_rd)       bus_rdata = FEATURE_WORD;
        else if (hit.pfn_rd)   bus_rdata = (sel_q == '0) ? pfn_q : '0;
        else if (hit.qsize_rd) bus_rdata = {16'h0, QUEUE_DEPTH};
        else if (hit.sel_rd)   bus_rdata = {16'h0, sel_q};
        else if (hit.stat_rd)  bus_rdata = {24'h0, status_q};
        else if (hit.isr_rd)   bus_rdata = {24'h0, isr_value};
        else if (hit.cfg_rd)   bus_rdata = cfg_rdata;
    end

    assign queue_pfn  = pfn_q;
    assign queue_sel  = sel_q;
    assign dev_status = status_q;

    assert_single_cmd_R13: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));
    assert_notify_source_R6: assert property (@(posedge clk) disable iff (rst)
        notify_valid |-> $past(bus_wr && bus_addr == OFF_NOTIFY && bus_size == 2'd1));
    assert_soft_reset_clears_R8: assert property (@(posedge clk) disable iff (rst)
        soft_reset |-> (dev_status == 8'h00 && queue_sel == 16'h0 && queue_pfn == 32'h0));
    assert_pfn_hidden_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFF_PFN && queue_sel != 16'h0) |-> bus_rdata == 32'h0);
    assert_bad_size_reads_zero_R13: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_size == 2'd3) |-> bus_rdata == 32'h0);
endmodule

// File: tb/pvio_regs_test.sv
module pvio_regs_test;
    localparam int CFG_LEN = 8;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [7:0]           bus_addr = '0;
    logic                 bus_rd = 1'b0;
    logic                 bus_wr = 1'b0;
    logic [1:0]           bus_size = '0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic                 irq_post = 1'b0;
    logic [CFG_LEN*8-1:0] cfg_bytes;
    logic [31:0]          queue_pfn;
    logic [15:0]          queue_sel;
    logic [7:0]           dev_status;
    logic                 notify_valid;
    logic [15:0]          notify_queue;
    logic                 soft_reset;
    logic                 irq;

    always #5 clk = ~clk;

    for (genvar i = 0; i < CFG_LEN; i++) begin : g_cfg
        assign cfg_bytes[i*8 +: 8] = 8'hA0 + 8'(i);
    end

    pvio_regs #(.CFG_LEN(CFG_LEN)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_post(irq_post), .cfg_bytes(cfg_bytes), .queue_pfn(queue_pfn),
        .queue_sel(queue_sel), .dev_status(dev_status), .notify_valid(notify_valid),
        .notify_queue(notify_queue), .soft_reset(soft_reset), .irq(irq)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // behavioural reference state
    logic [31:0] m_pfn;
    logic [15:0] m_sel;
    logic [7:0]  m_status;
    bit          m_isr;
    bit          m_notify;
    logic [15:0] m_nq;
    bit          m_srst;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pfn = '0; m_sel = '0; m_status = '0; m_isr = 0;
        m_notify = 0; m_nq = '0; m_srst = 0;
    endtask

    function automatic logic [31:0] model_read(logic [7:0] a, logic [1:0] s);
        logic [31:0] v = '0;
        int n;
        if (a == 8'h00 && s == 2) v = 32'd1;
        else if (a == 8'h08 && s == 2) v = (m_sel == 0) ? m_pfn : 32'd0;
        else if (a == 8'h0C && s == 1) v = 32'd32;
        else if (a == 8'h0E && s == 1) v = {16'h0, m_sel};
        else if (a == 8'h12 && s == 0) v = {24'h0, m_status};
        else if (a == 8'h13 && s == 0) v = {31'h0, m_isr};
        else if (a >= 8'h14 && a <= 8'h93 && s != 3) begin
            n = (s == 0) ? 1 : (s == 1) ? 2 : 4;
            for (int k = 0; k < n; k++) begin
                int idx = int'(a) - 'h14 + k;
                if (idx < CFG_LEN) v[k*8 +: 8] = 8'hA0 + 8'(idx);
            end
        end
        return v;
    endfunction

    function automatic string read_tag(logic [7:0] a, logic [1:0] s);
        if (a >= 8'h14 && a <= 8'h93 && s != 3) return "R12";
        if (a == 8'h00 && s == 2) return "R2";
        if (a == 8'h08 && s == 2) return "R3";
        if (a == 8'h0C && s == 1) return "R4";
        if (a == 8'h0E && s == 1) return "R5";
        if (a == 8'h12 && s == 0) return "R7";
        if (a == 8'h13 && s == 0) return "R10";
        return "R13";
    endfunction

    // one bus cycle: compare registered outputs, drive, compare read data, advance model
    task automatic step(input bit rd, input bit wr, input logic [7:0] a, input logic [1:0] s,
                        input logic [31:0] wd, input bit post);
        logic [31:0] exp_rd;
        bit clr, zwr;
        @(negedge clk);
        check(queue_pfn == m_pfn, "R3", "queue_pfn", queue_pfn, m_pfn);
        check(queue_sel == m_sel, "R5", "queue_sel", {16'h0, queue_sel}, {16'h0, m_sel});
        check(dev_status == m_status, "R7", "dev_status", {24'h0, dev_status}, {24'h0, m_status});
        check(irq == m_isr, "R9", "irq", {31'h0, irq}, {31'h0, m_isr});
        check(notify_valid == m_notify, "R6", "notify_valid", {31'h0, notify_valid}, {31'h0, m_notify});
        if (m_notify)
            check(notify_queue == m_nq, "R6", "notify_queue", {16'h0, notify_queue}, {16'h0, m_nq});
        check(soft_reset == m_srst, "R8", "soft_reset", {31'h0, soft_reset}, {31'h0, m_srst});
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_size = s; bus_wdata = wd; irq_post = post;
        #1;
        if (rd) begin
            exp_rd = model_read(a, s);
            check(bus_rdata == exp_rd, read_tag(a, s), "bus_rdata", bus_rdata, exp_rd);
        end
        clr = rd && a == 8'h13 && s == 0;
        zwr = wr && a == 8'h12 && s == 0 && wd[7:0] == 0;
        m_notify = wr && a == 8'h10 && s == 1;
        if (m_notify) m_nq = wd[15:0];
        m_srst = zwr;
        if (zwr) begin
            m_pfn = '0; m_sel = '0; m_status = '0;
        end else if (wr) begin
            if (a == 8'h08 && s == 2) m_pfn = wd;
            if (a == 8'h0E && s == 1) m_sel = wd[15:0];
            if (a == 8'h12 && s == 0) m_status = wd[7:0];
        end
        m_isr = (clr || zwr) ? post : (m_isr | post);
    endtask

    task automatic rd_(input logic [7:0] a, input logic [1:0] s);
        step(1, 0, a, s, 32'h0, 0);
    endtask
    task automatic wr_(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
        step(0, 1, a, s, d, 0);
    endtask
    task automatic idle(input bit post);
        step(0, 0, 8'h00, 2'd0, 32'h0, post);
    endtask

    localparam logic [7:0] POOL [16] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h0E, 8'h10, 8'h12, 8'h13,
                                          8'h14, 8'h17, 8'h1A, 8'h1B, 8'h40, 8'h93, 8'h95, 8'hFF};

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset values compared on the first step
        idle(0);
        // R2: feature word and guest feature write
        rd_(8'h00, 2);
        wr_(8'h04, 2, 32'hFFFF_FFFF);
        rd_(8'h00, 2);
        rd_(8'h08, 2);
        // R3: page frame number with select 0 and nonzero
        wr_(8'h08, 2, 32'h0001_2345);
        rd_(8'h08, 2);
        wr_(8'h0E, 1, 32'h0000_0005);
        rd_(8'h08, 2);
        rd_(8'h0E, 1);
        wr_(8'h0E, 1, 32'h0);
        rd_(8'h08, 2);
        // R4: queue size, and R13 wrong width
        rd_(8'h0C, 1);
        rd_(8'h0C, 2);
        wr_(8'h08, 0, 32'hFF);
        rd_(8'h08, 2);
        // R6: doorbell, back to back
        wr_(8'h10, 1, 32'h0000_0003);
        wr_(8'h10, 1, 32'h0000_0000);
        idle(0);
        // R7: status handshake
        wr_(8'h12, 0, 32'h01);
        wr_(8'h12, 0, 32'h07);
        rd_(8'h12, 0);
        wr_(8'h12, 0, 32'h80);
        // R9 / R10: post then read-clear
        idle(1);
        idle(0);
        rd_(8'h13, 0);
        rd_(8'h13, 0);
        rd_(8'h13, 1);
        // R11: post during read-clear
        idle(1);
        step(1, 0, 8'h13, 2'd0, 32'h0, 1);
        idle(0);
        rd_(8'h13, 0);
        // R8: zero status write with state set, then post coinciding with it (R11)
        wr_(8'h08, 2, 32'hCAFE_0001);
        wr_(8'h0E, 1, 32'h9);
        wr_(8'h12, 0, 32'h07);
        idle(1);
        wr_(8'h12, 0, 32'h00);
        idle(0);
        idle(1);
        step(0, 1, 8'h12, 2'd0, 32'h0, 1);
        idle(0);
        // R12: configuration window
        rd_(8'h14, 0);
        rd_(8'h15, 1);
        rd_(8'h14, 2);
        rd_(8'h1A, 2);
        rd_(8'h1B, 0);
        rd_(8'h1C, 0);
        rd_(8'h93, 2);
        wr_(8'h14, 0, 32'h55);
        rd_(8'h14, 2);
        rd_(8'h14, 3);
        // random phase
        for (int n = 0; n < 4000; n++) begin
            int kind = $urandom_range(0, 2);
            logic [7:0] a = POOL[$urandom_range(0, 15)];
            logic [1:0] s = 2'($urandom_range(0, 3));
            logic [31:0] d = $urandom();
            if ($urandom_range(0, 3) == 0) d[7:0] = 8'h00;
            step(kind == 0, kind == 1, a, s, d, $urandom_range(0, 5) == 0);
        end
        idle(0);
        idle(0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule